// File: doc/BRIEF.md
# Transfer Byte Counter and Shadow Address Tracker

This block follows the progress of one data transfer between a host and a storage bus. It holds a 24-bit remaining-byte count that steps down and a 32-bit shadow address that steps up. Both move together, and only when the bus datapath reports that a byte has completed. Because of this the shadow address always names the next byte still to be moved, and it never runs ahead of confirmed traffic. Software loads both values one byte at a time over a narrow write bus before it starts a transfer. Software can also zero the count with a single command.

Two sticky flags report progress. One flag records that the count has arrived at zero. The other records that a step was taken while the count was already zero, so that the counter rolled over to all ones. Software clears each flag by writing a one to the matching bit of a clear register. An enable register selects which flags drive the interrupt line.

Top module: `xfer_count_tracker`

## Requirements
- R1: After reset the count, the shadow address, both flags, both interrupt enables and `irq` are all zero.
- R2: A write to register 0, 1 or 2 replaces count bits 7:0, 15:8 or 23:16 respectively. The other count bytes are unchanged, and the new value appears on `xfer_cnt` one clock after the write.
- R3: A write to register 3, 4, 5 or 6 replaces shadow address bits 7:0, 15:8, 23:16 or 31:24 respectively. The other address bytes are unchanged.
- R4: When `byte_ok` is high and no load is present in that cycle, the count decreases by one and the shadow address increases by one (with carry), both visible one clock later. With `byte_ok` low and no write, neither value changes.
- R5: A step that takes the count from 1 to 0 sets the done flag (`done_flag`) in the same clock in which the count shows zero.
- R6: A step taken while the count is zero makes the count 0xFFFFFF and sets the wrap flag (`wrap_flag`). The shadow address still increases.
- R7: Writing register 7 with bit 0 set zeroes the count and sets the done flag. Writing register 7 with bit 0 clear leaves the count unchanged.
- R8: Writing register 8 clears the done flag for each 1 in bit 0 and the wrap flag for each 1 in bit 1. Bits written as 0 leave the matching flag unchanged.
- R9: If a flag is set and cleared in the same clock, it ends up set.
- R10: Register 9 holds the interrupt enables, with bit 0 for done and bit 1 for wrap. `irq` is high exactly when some flag is set and its enable is set, and it changes in the same clock as the flags.
- R11: A write to any of registers 0 through 7 in the same cycle as `byte_ok` takes priority. That step is dropped for both the count and the shadow address.
- R12: A count load that leaves the full 24-bit count at zero sets the done flag at once. A load that leaves the count nonzero does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| byte_ok | input | 1 | One byte confirmed transferred |
| xfer_cnt | output | 24 | Remaining byte count |
| xfer_addr | output | 32 | Shadow address of the next byte |
| done_flag | output | 1 | Sticky count-reached-zero flag |
| wrap_flag | output | 1 | Sticky count rollover flag |
| irq | output | 1 | Enabled flag interrupt |

## Verification
Every result is stored in one register stage. A write, a `byte_ok` pulse or a flag clear driven before a rising edge is therefore visible on `xfer_cnt`, `xfer_addr`, the flags and `irq` just after that same edge, one clock later. The bench drives its inputs on the falling edge and compares results on the next falling edge, so each comparison falls exactly one edge after its stimulus. Cases that need cycles to overlap, such as a load together with a step or a clear together with a set, are driven within a single cycle before that one sampled edge.

// File: rtl/xct_pkg.sv
package xct_pkg;
  localparam int FLAG_N      = 2;
  localparam int DONE_BIT    = 0;
  localparam int WRAP_BIT    = 1;
  localparam int CLR_CNT_BIT = 0;

  typedef struct packed {
    logic wrap;
    logic done;
  } xct_flags_t;
endpackage

// File: rtl/xct_down_counter.sv
module xct_down_counter #(
  parameter int W    = 24,
  parameter int BW   = 8,
  parameter int AW   = 4,
  parameter int BASE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          clr_cmd,
  input  logic          step,
  output logic [W-1:0]  cnt_q,
  output logic          zero_evt,
  output logic          wrap_evt
);
  localparam int NB = W / BW;

  logic [NB-1:0] lane_hit;
  logic [W-1:0]  lane_val;
  logic [W-1:0]  nxt;
  logic          loaded;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      assign lane_hit[g] = wr_en && (wr_addr == AW'(BASE + g));
      assign lane_val[g*BW +: BW] = lane_hit[g] ? wr_data : cnt_q[g*BW +: BW];
    end
  endgenerate

  always_comb begin
    loaded   = 1'b0;
    wrap_evt = 1'b0;
    nxt      = cnt_q;
    if (clr_cmd) begin
      nxt    = '0;
      loaded = 1'b1;
    end else if (|lane_hit) begin
      nxt    = lane_val;
      loaded = 1'b1;
    end else if (step) begin
      nxt      = cnt_q - 1'b1;
      wrap_evt = (cnt_q == '0);
    end
    zero_evt = (loaded || step) && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end
endmodule

// File: rtl/xct_up_counter.sv
module xct_up_counter #(
  parameter int W    = 32,
  parameter int BW   = 8,
  parameter int AW   = 4,
  parameter int BASE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          step,
  output logic [W-1:0]  val_q
);
  localparam int NB = W / BW;

  logic [NB-1:0] lane_hit;
  logic [W-1:0]  lane_val;
  logic [W-1:0]  nxt;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      assign lane_hit[g] = wr_en && (wr_addr == AW'(BASE + g));
      assign lane_val[g*BW +: BW] = lane_hit[g] ? wr_data : val_q[g*BW +: BW];
    end
  endgenerate

  always_comb begin
    if (|lane_hit) nxt = lane_val;
    else if (step) nxt = val_q + 1'b1;
    else           nxt = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= nxt;
  end
endmodule

// File: rtl/xct_flags.sv
module xct_flags
  import xct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_done,
  input  logic              set_wrap,
  input  logic              clr_wr,
  input  logic              en_wr,
  input  logic [FLAG_N-1:0] wr_bits,
  output xct_flags_t        flags_q,
  output logic              irq_q
);
  xct_flags_t        flags_nxt;
  logic [FLAG_N-1:0] en_q;
  logic [FLAG_N-1:0] en_nxt;
  logic [FLAG_N-1:0] clr_mask;
  logic [FLAG_N-1:0] set_mask;

  always_comb begin
    clr_mask           = clr_wr ? wr_bits : '0;
    set_mask           = '0;
    set_mask[DONE_BIT] = set_done;
    set_mask[WRAP_BIT] = set_wrap;
    flags_nxt          = xct_flags_t'((flags_q & ~clr_mask) | set_mask);
    en_nxt             = en_wr ? wr_bits : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      en_q    <= en_nxt;
      irq_q   <= |(flags_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/xfer_count_tracker.sv
module xfer_count_tracker
  import xct_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADR_W  = 32,
  parameter int BUS_W  = 8,
  parameter int RA_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             byte_ok,
  output logic [CNT_W-1:0] xfer_cnt,
  output logic [ADR_W-1:0] xfer_addr,
  output logic             done_flag,
  output logic             wrap_flag,
  output logic             irq
);
  localparam int CNT_NB    = CNT_W / BUS_W;
  localparam int ADR_NB    = ADR_W / BUS_W;
  localparam int CNT_BASE  = 0;
  localparam int ADR_BASE  = CNT_NB;
  localparam int CTRL_ADDR = ADR_BASE + ADR_NB;
  localparam int W1C_ADDR  = CTRL_ADDR + 1;
  localparam int EN_ADDR   = CTRL_ADDR + 2;

  logic       load_hit;
  logic       step;
  logic       clr_cmd;
  logic       zero_evt;
  logic       wrap_evt;
  xct_flags_t flags;

  assign load_hit = wr_en && (wr_addr <= RA_W'(CTRL_ADDR));
  assign step     = byte_ok && !load_hit;
  assign clr_cmd  = wr_en && (wr_addr == RA_W'(CTRL_ADDR)) && wr_data[CLR_CNT_BIT];

  xct_down_counter #(
    .W(CNT_W), .BW(BUS_W), .AW(RA_W), .BASE(CNT_BASE)
  ) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_cmd(clr_cmd), .step(step), .cnt_q(xfer_cnt),
    .zero_evt(zero_evt), .wrap_evt(wrap_evt)
  );

  xct_up_counter #(
    .W(ADR_W), .BW(BUS_W), .AW(RA_W), .BASE(ADR_BASE)
  ) u_adr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .step(step), .val_q(xfer_addr)
  );

  xct_flags u_flags (
    .clk(clk), .rst(rst),
    .set_done(zero_evt), .set_wrap(wrap_evt),
    .clr_wr(wr_en && (wr_addr == RA_W'(W1C_ADDR))),
    .en_wr(wr_en && (wr_addr == RA_W'(EN_ADDR))),
    .wr_bits(wr_data[FLAG_N-1:0]),
    .flags_q(flags), .irq_q(irq)
  );

  assign done_flag = flags.done;
  assign wrap_flag = flags.wrap;
endmodule

// File: rtl/xct_checker.sv
module xct_checker #(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32,
  parameter int RA_W  = 4,
  parameter int LAST_LOAD = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [RA_W-1:0]  wr_addr,
  input logic             byte_ok,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic [ADR_W-1:0] xfer_addr,
  input logic             done_flag,
  input logic             wrap_flag,
  input logic             irq
);
  logic ld;
  assign ld = wr_en && (wr_addr <= RA_W'(LAST_LOAD));

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && !ld) |=> (xfer_cnt == CNT_W'($past(xfer_cnt) - 1'b1)));

  a_r4_adr_step: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && !ld) |=> (xfer_addr == ADR_W'($past(xfer_addr) + 1'b1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!byte_ok && !wr_en) |=> ($stable(xfer_cnt) && $stable(xfer_addr)));

  a_r5_done_at_zero: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && !ld && xfer_cnt == CNT_W'(1)) |=> done_flag);

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && !ld && xfer_cnt == '0) |=> (wrap_flag && xfer_cnt == '1));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!done_flag && !wrap_flag) |-> !irq);
endmodule

bind xfer_count_tracker xct_checker #(
  .CNT_W(CNT_W), .ADR_W(ADR_W), .RA_W(RA_W), .LAST_LOAD(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .byte_ok(byte_ok),
  .xfer_cnt(xfer_cnt), .xfer_addr(xfer_addr), .done_flag(done_flag),
  .wrap_flag(wrap_flag), .irq(irq)
);

// File: tb/xfer_count_tracker_bench.sv
module xfer_count_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        byte_ok = 1'b0;
  logic [23:0] xfer_cnt;
  logic [31:0] xfer_addr;
  logic        done_flag, wrap_flag, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xfer_count_tracker u_xfer_count_tracker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_ok(byte_ok), .xfer_cnt(xfer_cnt), .xfer_addr(xfer_addr),
    .done_flag(done_flag), .wrap_flag(wrap_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      byte_ok = 1'b1;
      @(negedge clk);
    end
    byte_ok = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cnt", 32'(xfer_cnt), 0);
    check("R1 addr", xfer_addr, 0);
    check("R1 flags", {30'd0, wrap_flag, done_flag}, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_loads;
    wr(4'd0, 8'h12); wr(4'd1, 8'h34); wr(4'd2, 8'h56);
    check("R2 count bytes", 32'(xfer_cnt), 32'h563412);
    wr(4'd1, 8'hAB);
    check("R2 single byte", 32'(xfer_cnt), 32'h56AB12);
    wr(4'd3, 8'hFE); wr(4'd4, 8'hFF); wr(4'd5, 8'h00); wr(4'd6, 8'h10);
    check("R3 address bytes", xfer_addr, 32'h1000FFFE);
    check("R12 nonzero load no done", 32'(done_flag), 0);
  endtask

  task automatic t_step;
    pulse(3);
    check("R4 count step", 32'(xfer_cnt), 32'h56AB0F);
    check("R4 address step carry", xfer_addr, 32'h10010001);
    repeat (3) @(negedge clk);
    check("R4 idle hold cnt", 32'(xfer_cnt), 32'h56AB0F);
    check("R4 idle hold addr", xfer_addr, 32'h10010001);
  endtask

  task automatic t_done_wrap;
    wr(4'd2, 8'h00); wr(4'd1, 8'h00); wr(4'd0, 8'h02);
    pulse(1);
    check("R5 no done at one", 32'(done_flag), 0);
    pulse(1);
    check("R5 count zero", 32'(xfer_cnt), 0);
    check("R5 done set", 32'(done_flag), 1);
    pulse(1);
    check("R6 wrap count", 32'(xfer_cnt), 32'hFFFFFF);
    check("R6 wrap flag", 32'(wrap_flag), 1);
    check("R6 address still moves", xfer_addr, 32'h10010004);
  endtask

  task automatic t_w1c_irq;
    check("R10 disabled no irq", 32'(irq), 0);
    wr(4'd8, 8'h00);
    check("R8 zero write keeps", {30'd0, wrap_flag, done_flag}, 3);
    wr(4'd9, 8'h01);
    check("R10 irq on done", 32'(irq), 1);
    wr(4'd8, 8'h02);
    check("R8 wrap cleared only", {30'd0, wrap_flag, done_flag}, 1);
    wr(4'd8, 8'h01);
    check("R8 done cleared", 32'(done_flag), 0);
    check("R10 irq drops", 32'(irq), 0);
  endtask

  task automatic t_clear_cmd;
    wr(4'd7, 8'h00);
    check("R7 bit clear no effect", 32'(xfer_cnt), 32'hFFFFFF);
    check("R7 no done", 32'(done_flag), 0);
    wr(4'd7, 8'h01);
    check("R7 count zeroed", 32'(xfer_cnt), 0);
    check("R7 done set", 32'(done_flag), 1);
    check("R10 irq from clear", 32'(irq), 1);
    wr(4'd8, 8'h01);
  endtask

  task automatic t_set_beats_clear;
    wr(4'd0, 8'h01);
    byte_ok = 1'b1;
    wr(4'd8, 8'h01);
    byte_ok = 1'b0;
    check("R9 count zero", 32'(xfer_cnt), 0);
    check("R9 set wins", 32'(done_flag), 1);
    wr(4'd8, 8'h03);
  endtask

  task automatic t_priority;
    logic [31:0] a0;
    wr(4'd0, 8'h05);
    a0 = xfer_addr;
    byte_ok = 1'b1;
    wr(4'd0, 8'h09);
    byte_ok = 1'b0;
    check("R11 load wins cnt", 32'(xfer_cnt), 32'h9);
    check("R11 addr not stepped", xfer_addr, a0);
    byte_ok = 1'b1;
    wr(4'd4, 8'h00);
    byte_ok = 1'b0;
    check("R11 addr load drops step cnt", 32'(xfer_cnt), 32'h9);
  endtask

  task automatic t_zero_load;
    wr(4'd8, 8'h03);
    check("R12 pre clear", 32'(done_flag), 0);
    wr(4'd0, 8'h00);
    check("R12 zero load count", 32'(xfer_cnt), 0);
    check("R12 zero load sets done", 32'(done_flag), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_step();
    t_done_wrap();
    t_w1c_irq();
    t_clear_cmd();
    t_set_beats_clear();
    t_priority();
    t_zero_load();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule